// File: doc/BRIEF.md
# Wrapped-order line fill sequencer

This block turns a request to fill one 32-byte cache line into a burst of data beats on the memory bus. The line holds eight 32-bit words and starts on an 8-word boundary. The burst starts with the double word the requester needs, and the beat addresses then wrap around inside the line. A runtime setting picks the bus width. On a 64-bit bus the line arrives in four beats of two words each. On a 32-bit bus it arrives in eight beats of one word each.

Each accepted beat is passed to the line storage as a registered write. The write carries a double-word index, a two-lane word mask and the data. One pulse marks the moment the critical double word is complete. This lets the consumer restart before the burst ends. A second pulse marks the final beat of the line.

The controller has three states: `ST_IDLE`, `ST_CRIT` and `ST_FILL`.
- `ST_IDLE` waits for a request. It moves to `ST_CRIT` when it accepts one.
- `ST_CRIT` collects the beats of the critical double word. It moves to `ST_FILL` on the beat that completes that double word: the first beat on a 64-bit bus, the second on a 32-bit bus. If that beat is also the last beat of the line, it returns straight to `ST_IDLE`.
- `ST_FILL` collects the remaining beats. It returns to `ST_IDLE` on the final beat.

Top module: `burst_fill_seq`

## Requirements
- R1: During and right after reset, `req_ready` is 1, and `bus_req`, `wr_mask`, `crit_pulse` and `line_done` are all 0.
- R2: `req_ready` is 1 only in `ST_IDLE`. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_valid` and the request fields are ignored while a burst is in progress.
- R3: The first beat address is `{req_line, 2*req_crit_dw, 2'b00}`: the even word of the critical double word, as a byte address.
- R4: With `cfg_narrow`=0 (64-bit bus), the burst has four beats. The double-word index of beat k is `(req_crit_dw + k) mod 4`. `bus_addr` carries that double word's even word, and the line field stays constant.
- R5: With `cfg_narrow`=1 (32-bit bus), the burst has eight beats. The word index of beat k is `(2*req_crit_dw + k) mod 8`.
- R6: A beat is accepted on an edge where `bus_req` and `beat_valid` are both high. In the next cycle, `wr_dw` is the double-word index of that beat, and the write depends on the width:
  - 64-bit bus: `wr_mask`=2'b11 and `wr_data` equals `beat_data`.
  - 32-bit bus: `wr_mask` is 2'b01 for an even word or 2'b10 for an odd word, and both 32-bit lanes of `wr_data` carry `beat_data[31:0]`.
- R7: `crit_pulse` is high for exactly one cycle per line. It comes in the cycle after the beat that completes the critical double word: beat 0 on a 64-bit bus, beat 1 on a 32-bit bus.
- R8: `line_done` is high for one cycle, in the cycle after the final beat. In that same cycle `req_ready` is already 1.
- R9: The width setting is sampled when a request is accepted. Changing `cfg_narrow` during a burst changes neither the beat count nor the addresses of that burst.
- R10: While `beat_valid` is low the burst stalls. `bus_addr` holds its value and `wr_mask` is 0 in the following cycle. `beat_valid` has no effect in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_narrow | input | 1 | 1 = 32-bit bus (eight beats), 0 = 64-bit bus (four beats) |
| req_valid | input | 1 | Fill request |
| req_line | input | ADDR_W-5 | Line address (byte address bits above the line offset) |
| req_crit_dw | input | 2 | Index of the critical double word within the line |
| req_ready | output | 1 | Sequencer idle, request can be accepted |
| bus_req | output | 1 | Burst in progress |
| bus_addr | output | ADDR_W | Byte address of the current beat |
| beat_valid | input | 1 | Bus presents a beat this cycle |
| beat_data | input | 64 | Beat data; only bits 31:0 are used on a 32-bit bus |
| wr_mask | output | 2 | Word lanes written this cycle (bit 0 = even word) |
| wr_dw | output | 2 | Double-word index within the line for this write |
| wr_data | output | 64 | Write data, lane 1 in bits 63:32 |
| crit_pulse | output | 1 | Critical double word complete |
| line_done | output | 1 | Final beat of the line written |

## Verification
A wrong word pointer or beat counter shows up on `bus_addr` for the very next beat. It then shows on `wr_dw` and `wr_mask` one cycle after that beat is taken, so an ordering error is visible within two cycles. A state register stuck in `ST_CRIT` or `ST_FILL` shows as a missing or repeated `crit_pulse`, a `line_done` in the wrong cycle, or `req_ready` staying low after the final beat. A width setting that is not held for the burst changes the beat count and the address step, and both show at the ports on the following beat.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CRIT = 2'd1,
        ST_FILL = 2'd2
    } fill_state_e;

endpackage

// File: rtl/bfs_ptr.sv
// Beat counter and wrapping word pointer for one line burst.
module bfs_ptr #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] start_idx,
    input  logic             narrow,
    input  logic             advance,
    output logic [IDX_W-1:0] idx_q,
    output logic             last_beat,
    output logic             crit_beat
);
    localparam int          WORDS      = 1 << IDX_W;
    localparam logic [IDX_W-1:0] NARROW_LAST = IDX_W'(WORDS - 1);
    localparam logic [IDX_W-1:0] WIDE_LAST   = IDX_W'(WORDS / 2 - 1);
    localparam logic [IDX_W-1:0] STEP_ONE    = IDX_W'(1);
    localparam logic [IDX_W-1:0] STEP_TWO    = IDX_W'(2);

    logic [IDX_W-1:0] beat_q;
    logic [IDX_W-1:0] step;

    assign step      = narrow ? STEP_ONE : STEP_TWO;
    assign last_beat = (beat_q == (narrow ? NARROW_LAST : WIDE_LAST));
    // the critical double word is complete after one wide or two narrow beats
    assign crit_beat = (beat_q == (narrow ? STEP_ONE : '0));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            beat_q <= '0;
        end else if (load) begin
            idx_q  <= start_idx;
            beat_q <= '0;
        end else if (advance) begin
            idx_q  <= idx_q + step;   // wraps modulo the line length
            beat_q <= beat_q + STEP_ONE;
        end
    end
endmodule

// File: rtl/bfs_lane.sv
// Maps one bus beat onto the two word lanes of a double-word write.
module bfs_lane #(
    parameter int IDX_W  = 3,
    parameter int WORD_W = 32
) (
    input  logic                  narrow,
    input  logic [IDX_W-1:0]      idx,
    input  logic [2*WORD_W-1:0]   data,
    output logic [1:0]            mask,
    output logic [IDX_W-2:0]      dw,
    output logic [2*WORD_W-1:0]   wdata
);
    assign dw = idx[IDX_W-1:1];

    for (genvar g = 0; g < 2; g++) begin : g_lane
        always_comb begin
            if (narrow) begin
                mask[g]                       = (idx[0] == g[0]);
                wdata[g*WORD_W +: WORD_W]     = data[WORD_W-1:0];
            end else begin
                mask[g]                       = 1'b1;
                wdata[g*WORD_W +: WORD_W]     = data[g*WORD_W +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/burst_fill_seq.sv
module burst_fill_seq
    import bfs_pkg::*;
#(
    parameter int  ADDR_W     = 32,
    parameter int  WORD_W     = 32,
    parameter int  LINE_WORDS = 8,
    localparam int IDX_W      = $clog2(LINE_WORDS),
    localparam int DW_W       = IDX_W - 1,
    localparam int BYTE_SH    = $clog2(WORD_W / 8),
    localparam int OFF_W      = IDX_W + BYTE_SH,
    localparam int LINE_W     = ADDR_W - OFF_W,
    localparam int BUS_W      = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_narrow,
    input  logic              req_valid,
    input  logic [LINE_W-1:0] req_line,
    input  logic [DW_W-1:0]   req_crit_dw,
    output logic              req_ready,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              beat_valid,
    input  logic [BUS_W-1:0]  beat_data,
    output logic [1:0]        wr_mask,
    output logic [DW_W-1:0]   wr_dw,
    output logic [BUS_W-1:0]  wr_data,
    output logic              crit_pulse,
    output logic              line_done
);
    fill_state_e       state_q, state_d;
    logic              mode_q;
    logic [LINE_W-1:0] line_q;
    logic              accept, take;
    logic [IDX_W-1:0]  idx_q;
    logic              last_beat, crit_beat;
    logic [1:0]        lane_mask;
    logic [DW_W-1:0]   lane_dw;
    logic [BUS_W-1:0]  lane_data;

    logic [1:0]        wr_mask_q;
    logic [DW_W-1:0]   wr_dw_q;
    logic [BUS_W-1:0]  wr_data_q;
    logic              crit_q, done_q;

    assign accept = (state_q == ST_IDLE) && req_valid;
    assign take   = (state_q != ST_IDLE) && beat_valid;

    bfs_ptr #(.IDX_W(IDX_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .start_idx ({req_crit_dw, 1'b0}),
        .narrow    (mode_q),
        .advance   (take),
        .idx_q     (idx_q),
        .last_beat (last_beat),
        .crit_beat (crit_beat)
    );

    bfs_lane #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_lane (
        .narrow (mode_q),
        .idx    (idx_q),
        .data   (beat_data),
        .mask   (lane_mask),
        .dw     (lane_dw),
        .wdata  (lane_data)
    );

    // request capture: line and bus width held for the whole burst
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            line_q <= '0;
        end else if (accept) begin
            mode_q <= cfg_narrow;
            line_q <= req_line;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_CRIT;
            ST_CRIT: if (take && crit_beat) state_d = last_beat ? ST_IDLE : ST_FILL;
            ST_FILL: if (take && last_beat) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // registered write port and event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_mask_q <= '0;
            wr_dw_q   <= '0;
            wr_data_q <= '0;
            crit_q    <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            wr_mask_q <= take ? lane_mask : 2'b00;
            if (take) begin
                wr_dw_q   <= lane_dw;
                wr_data_q <= lane_data;
            end
            crit_q <= take && (state_q == ST_CRIT) && crit_beat;
            done_q <= take && last_beat;
        end
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign bus_req    = (state_q != ST_IDLE);
    assign bus_addr   = {line_q, idx_q, {BYTE_SH{1'b0}}};
    assign wr_mask    = wr_mask_q;
    assign wr_dw      = wr_dw_q;
    assign wr_data    = wr_data_q;
    assign crit_pulse = crit_q;
    assign line_done  = done_q;
endmodule

// File: rtl/bfs_chk.sv
module bfs_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              bus_req,
    input logic              beat_valid,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        wr_mask,
    input logic              crit_pulse,
    input logic              line_done,
    input logic              mode_q
);
    p_write_on_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && beat_valid) |=> (wr_mask != 2'b00));

    p_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req || !beat_valid) |=> (wr_mask == 2'b00));

    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !beat_valid) |=> $stable(bus_addr));

    p_line_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $past(bus_req)) |->
            (bus_addr[ADDR_W-1:OFF_W] == $past(bus_addr[ADDR_W-1:OFF_W])));

    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $past(bus_req)) |-> $stable(mode_q));

    p_crit_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        crit_pulse |=> !crit_pulse);

    p_crit_from_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        crit_pulse |-> $past(bus_req && beat_valid));

    p_done_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> (req_ready && $past(bus_req && beat_valid)));
endmodule

bind burst_fill_seq bfs_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .bus_req    (bus_req),
    .beat_valid (beat_valid),
    .bus_addr   (bus_addr),
    .wr_mask    (wr_mask),
    .crit_pulse (crit_pulse),
    .line_done  (line_done),
    .mode_q     (mode_q)
);

// File: tb/burst_fill_seq_tb.sv
module burst_fill_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_narrow = 1'b0;
    logic        req_valid = 1'b0;
    logic [26:0] req_line = '0;
    logic [1:0]  req_crit_dw = '0;
    logic        req_ready, bus_req;
    logic [31:0] bus_addr;
    logic        beat_valid = 1'b0;
    logic [63:0] beat_data = '0;
    logic [1:0]  wr_mask;
    logic [1:0]  wr_dw;
    logic [63:0] wr_data;
    logic        crit_pulse, line_done;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    burst_fill_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_narrow(cfg_narrow),
        .req_valid(req_valid), .req_line(req_line), .req_crit_dw(req_crit_dw),
        .req_ready(req_ready), .bus_req(bus_req), .bus_addr(bus_addr),
        .beat_valid(beat_valid), .beat_data(beat_data),
        .wr_mask(wr_mask), .wr_dw(wr_dw), .wr_data(wr_data),
        .crit_pulse(crit_pulse), .line_done(line_done)
    );

    always #5 clk = ~clk;

    // fields: narrow | crit_dw[1:0] | line[26:0] | stall | noise
    localparam logic [31:0] VEC [0:5] = '{
        {1'b0, 2'd0, 27'h0000123, 1'b0, 1'b0},
        {1'b0, 2'd2, 27'h7ABCDE1, 1'b1, 1'b0},
        {1'b1, 2'd0, 27'h0000040, 1'b0, 1'b0},
        {1'b1, 2'd3, 27'h5555555, 1'b1, 1'b0},
        {1'b0, 2'd3, 27'h00FF00F, 1'b0, 1'b1},
        {1'b1, 2'd1, 27'h3C3C3C3, 1'b1, 1'b1}
    };

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 50000", cycles);
            summary();
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] wd(input logic [31:0] a);
        return (a * 32'h9E3779B9) ^ 32'h5A5A0F0F;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_line(input bit narrow, input logic [1:0] cdw, input logic [26:0] line,
                            input bit stall, input bit noise);
        int nb = narrow ? 8 : 4;
        int cb = narrow ? 1 : 0;
        cfg_narrow  = narrow;
        req_valid   = 1'b1;
        req_line    = line;
        req_crit_dw = cdw;
        chk(req_ready == 1'b1, "R2 ready before accept", 64'(req_ready), 64'd1);
        tick();
        req_valid = noise;
        if (noise) begin
            req_line    = ~line;
            req_crit_dw = cdw + 2'd1;
            cfg_narrow  = ~narrow;
        end
        chk(bus_req == 1'b1 && req_ready == 1'b0, "R2 busy after accept",
            64'({bus_req, req_ready}), 64'b10);
        for (int k = 0; k < nb; k++) begin
            logic [2:0]  idx;
            logic [31:0] ea;
            idx = narrow ? 3'((2 * cdw + k) % 8) : 3'(2 * ((cdw + k) % 4));
            ea  = {line, idx, 2'b00};
            if (stall && k == 1) begin
                beat_valid = 1'b0;
                tick();
                chk(wr_mask == 2'b00, "R10 no write on stall", 64'(wr_mask), 64'd0);
            end
            chk(bus_addr == ea, k == 0 ? "R3 first beat address" :
                (noise ? "R9 address with cfg change" : (narrow ? "R5 narrow order" : "R4 wide order")),
                64'(bus_addr), 64'(ea));
            if (k == nb - 1) req_valid = 1'b0;
            beat_valid = 1'b1;
            beat_data  = narrow ? {32'hDEADBEEF, wd(ea)} : {wd(ea + 32'd4), wd(ea)};
            tick();
            beat_valid = 1'b0;
            if (narrow) begin
                chk(wr_mask == (idx[0] ? 2'b10 : 2'b01) && wr_dw == idx[2:1] &&
                    wr_data == {wd(ea), wd(ea)}, "R6 narrow write",
                    {28'd0, wr_mask, wr_dw, wr_data[31:0]}, {28'd0, (idx[0] ? 2'b10 : 2'b01), idx[2:1], wd(ea)});
            end else begin
                chk(wr_mask == 2'b11 && wr_dw == idx[2:1] && wr_data == {wd(ea + 32'd4), wd(ea)},
                    "R6 wide write", wr_data, {wd(ea + 32'd4), wd(ea)});
            end
            chk(crit_pulse == (k == cb), "R7 critical pulse", 64'(crit_pulse), 64'(k == cb));
            chk(line_done == (k == nb - 1), "R8 line done", 64'(line_done), 64'(k == nb - 1));
        end
        chk(req_ready == 1'b1 && bus_req == 1'b0, "R8 ready with line done",
            64'({req_ready, bus_req}), 64'b10);
        req_valid = 1'b0;
        tick();
        chk(line_done == 1'b0 && crit_pulse == 1'b0, "R8 pulses end",
            64'({line_done, crit_pulse}), 64'd0);
    endtask

    initial begin
        tick();
        tick();
        chk(req_ready == 1'b1 && bus_req == 1'b0 && wr_mask == 2'b00 && !crit_pulse && !line_done,
            "R1 reset state", 64'({req_ready, bus_req, wr_mask, crit_pulse, line_done}), 64'b100000);
        rst_n = 1'b1;
        tick();
        chk(req_ready == 1'b1 && bus_req == 1'b0, "R1 idle after reset",
            64'({req_ready, bus_req}), 64'b10);

        foreach (VEC[i]) begin
            run_line(VEC[i][31], VEC[i][30:29], VEC[i][28:2], VEC[i][1], VEC[i][0]);
        end

        // beat_valid while idle has no effect
        beat_valid = 1'b1;
        beat_data  = 64'h1111_2222_3333_4444;
        tick();
        beat_valid = 1'b0;
        chk(wr_mask == 2'b00 && bus_req == 1'b0, "R10 beat ignored when idle",
            64'({wr_mask, bus_req}), 64'd0);

        // reset in the middle of a burst
        cfg_narrow = 1'b1;
        req_valid  = 1'b1;
        req_line   = 27'h0ABCDEF;
        req_crit_dw = 2'd2;
        tick();
        req_valid  = 1'b0;
        beat_valid = 1'b1;
        tick();
        beat_valid = 1'b0;
        rst_n = 1'b0;
        tick();
        chk(req_ready == 1'b1 && bus_req == 1'b0 && wr_mask == 2'b00 && !crit_pulse,
            "R1 reset during burst", 64'({req_ready, bus_req, wr_mask, crit_pulse}), 64'b10000);
        rst_n = 1'b1;
        tick();

        // a full burst after the aborted one
        run_line(1'b0, 2'd1, 27'h1234567, 1'b0, 1'b0);

        summary();
    end
endmodule